// File: doc/BRIEF.md
# Window Threshold Alarm Interrupt

This block watches two signed measurements, a charge accumulator reading and a temperature reading. It raises an active-low interrupt on a shared general-purpose output pin when either reading leaves a window. Each window has an upper and a lower limit held in six bytes of ordinary user RAM. The block reads those bytes on its own through a small combinational register-file read port. It scans the six addresses in a loop and keeps a shadow copy of every limit.

A reading is compared only in the cycle its update strobe is high. The block compares the signed high-order part of each reading: the top 16 bits of the accumulator and the top 8 bits of the temperature. Each channel keeps two flags. The first is a level flag that says whether the last sampled reading was outside the window. The second is a sticky flag that records that an excursion happened. Software can clear the sticky flag only after the reading is back inside the window.

While the alarm enable is high, the block owns the pin and drives it low whenever a sticky flag is set. The ordinary drive request is then ignored. While the enable is low, the pin simply follows the ordinary drive request, and all alarm state is held clear.

Top module: `thr_alarm`

## Requirements
- R1: While `rst` is high, `pio_n` is 1 and `alarm_flags` and `window_out` are 0 after the next clock edge.
- R2: `rf_addr` always lies in 0x80..0x85 and steps through those addresses one per cycle. Byte 0x80 is the high byte and 0x81 the low byte of the accumulator upper limit. 0x82 (high) and 0x83 (low) hold the accumulator lower limit. 0x84 holds the temperature upper limit and 0x85 the temperature lower limit. All limits are two's complement.
- R3: The accumulator channel (bit 0 of each flag output) takes the signed top 16 bits of `acc_val`. It is outside when that value is greater than the upper limit or less than the lower limit. A value equal to either limit is inside.
- R4: The temperature channel (bit 1 of each flag output) takes the signed top 8 bits of `temp_val` and applies the same window rule against its limits.
- R5: A channel's `window_out` bit updates only on a clock edge where that channel's strobe is high. Between strobes it holds its value.
- R6: A strobe that finds the value outside sets the channel's `alarm_flags` bit. A high `clr_flags` bit clears that flag only when the channel's window state after the edge is inside. Otherwise the flag stays set.
- R7: With `alarm_en` high, `pio_n` is registered. It goes to 0 one edge after any `alarm_flags` bit is 1 and goes to 1 one edge after both are 0. `pio_req` has no effect.
- R8: With `alarm_en` low, `pio_n` equals the inverse of `pio_req` one edge later. Both flag outputs are cleared at the edge, and strobes have no effect.
- R9: When a strobe finds the value outside in the same cycle as a clear request, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_en | input | 1 | Alarm enable; hands the pin to the alarm |
| pio_req | input | 1 | Ordinary pin drive request (1 pulls the pin low) |
| acc_val | input | ACC_W | Signed accumulator reading |
| acc_stb | input | 1 | Accumulator update strobe |
| temp_val | input | TEMP_W | Signed temperature reading |
| temp_stb | input | 1 | Temperature update strobe |
| clr_flags | input | 2 | Per-channel sticky-flag clear request |
| rf_addr | output | 8 | Limit RAM read address |
| rf_rdata | input | 8 | Limit RAM read data, valid in the same cycle |
| pio_n | output | 1 | Active-low pin drive |
| alarm_flags | output | 2 | Sticky excursion flags (bit 0 accumulator, bit 1 temperature) |
| window_out | output | 2 | Outside-window state from the last strobe |

## Verification
A reference model in the bench runs alongside the block and is compared with `pio_n` and both flag outputs at every clock.

A wrong comparison or a swapped limit byte appears in `window_out` one edge after the strobe. It reaches the pin one edge after that. A sticky flag that clears too early, or fails to set, shows on `alarm_flags` at the first edge where it goes wrong. It shows on `pio_n` one cycle later.

A corrupted limit shadow stays hidden until the next strobe that lands between the corrupted value and the true one. For that reason the stimulus places readings exactly on each limit and one step past it. It also reloads the limits and repeats those checks.

// File: rtl/wta_pkg.sv
package wta_pkg;

    // Limit RAM window
    localparam logic [7:0] LIM_BASE  = 8'h80;
    localparam int         LIM_BYTES = 6;
    localparam int         LIM_IDX_W = $clog2(LIM_BYTES);

    // Common signed compare width
    localparam int CMP_W = 16;

    // Channel widths of the compared fields
    localparam int ACC_CMP_W = 16;
    localparam int TMP_CMP_W = 8;

    // Channel indices
    typedef enum logic [0:0] {
        CH_ACC = 1'b0,
        CH_TMP = 1'b1
    } chan_e;

    // Limit shadow
    typedef struct packed {
        logic signed [ACC_CMP_W-1:0] acc_up;
        logic signed [ACC_CMP_W-1:0] acc_dn;
        logic signed [TMP_CMP_W-1:0] tmp_up;
        logic signed [TMP_CMP_W-1:0] tmp_dn;
    } lim_set_t;

    // Per-channel alarm state
    typedef struct packed {
        logic outside;
        logic sticky;
    } chan_state_t;

    // Value to load into a limit byte at reset: widest window
    function automatic logic [7:0] reset_byte(input int idx);
        case (idx)
            0:       return 8'h7F;
            1:       return 8'hFF;
            2:       return 8'h80;
            3:       return 8'h00;
            4:       return 8'h7F;
            default: return 8'h80;
        endcase
    endfunction

    // Signed window test
    function automatic logic beyond(input logic signed [CMP_W-1:0] v,
                                    input logic signed [CMP_W-1:0] up,
                                    input logic signed [CMP_W-1:0] dn);
        return (v > up) || (v < dn);
    endfunction

endpackage

// File: rtl/wta_limit_fetch.sv
module wta_limit_fetch
    import wta_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output logic [7:0] rf_addr,
    input  logic [7:0] rf_rdata,
    output lim_set_t   lim
);

    localparam logic [LIM_IDX_W-1:0] LAST_IDX = LIM_IDX_W'(LIM_BYTES - 1);

    logic [LIM_IDX_W-1:0] idx_q;
    logic [7:0]           shadow_q [LIM_BYTES];

    // Scan pointer walks the limit bytes in a loop
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_q == LAST_IDX) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign rf_addr = LIM_BASE + 8'(idx_q);

    // Capture the byte addressed this cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LIM_BYTES; i++) begin
                shadow_q[i] <= reset_byte(i);
            end
        end else begin
            for (int i = 0; i < LIM_BYTES; i++) begin
                if (idx_q == LIM_IDX_W'(i)) begin
                    shadow_q[i] <= rf_rdata;
                end
            end
        end
    end

    // High byte at the lower address
    always_comb begin
        lim.acc_up = {shadow_q[0], shadow_q[1]};
        lim.acc_dn = {shadow_q[2], shadow_q[3]};
        lim.tmp_up = shadow_q[4];
        lim.tmp_dn = shadow_q[5];
    end

    AST_SCAN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (rf_addr >= LIM_BASE) && (rf_addr < LIM_BASE + 8'(LIM_BYTES))); // R2

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
        (rf_addr != LIM_BASE + 8'(LIM_BYTES - 1)) |=> (rf_addr == $past(rf_addr) + 8'd1)); // R2

endmodule

// File: rtl/wta_win_chan.sv
module wta_win_chan
    import wta_pkg::*;
#(
    parameter int VAL_W = 16,
    parameter int CW    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [VAL_W-1:0]     value,
    input  logic                 stb,
    input  logic                 clr,
    input  logic signed [CW-1:0] lim_up,
    input  logic signed [CW-1:0] lim_dn,
    output chan_state_t          st
);

    logic signed [CW-1:0]    v_top;
    logic signed [CMP_W-1:0] v_ext;
    logic signed [CMP_W-1:0] up_ext;
    logic signed [CMP_W-1:0] dn_ext;
    logic                    hit;
    chan_state_t             st_q;
    chan_state_t             st_d;

    assign v_top  = value[VAL_W-1 -: CW];
    assign v_ext  = CMP_W'(v_top);
    assign up_ext = CMP_W'(lim_up);
    assign dn_ext = CMP_W'(lim_dn);
    assign hit    = beyond(v_ext, up_ext, dn_ext);

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else begin
            if (stb) begin
                st_d.outside = hit;
            end
            // Clear honoured only once the window state is inside
            if (clr && !st_d.outside) begin
                st_d.sticky = 1'b0;
            end
            // An excursion seen now always wins
            if (stb && hit) begin
                st_d.sticky = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    AST_STICKY_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(st.sticky) |-> $past(stb && en)); // R6

    AST_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (en && st.sticky && st.outside && !stb) |=> st.sticky); // R6

    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !stb) |=> $stable(st.outside)); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (en && stb && clr && hit) |=> st.sticky); // R9

    AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == '0)); // R8

endmodule

// File: rtl/wta_pio_drive.sv
module wta_pio_drive (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic req,
    input  logic any_alarm,
    output logic pio_n
);

    logic pio_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pio_n_q <= 1'b1;
        end else if (en) begin
            pio_n_q <= !any_alarm;
        end else begin
            pio_n_q <= !req;
        end
    end

    assign pio_n = pio_n_q;

    AST_PIN_ALARM: assert property (@(posedge clk) disable iff (rst)
        (en && any_alarm) |=> !pio_n); // R7

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (en && !any_alarm) |=> pio_n); // R7

    AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pio_n == !$past(req))); // R8

endmodule

// File: rtl/thr_alarm.sv
module thr_alarm
    import wta_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int TEMP_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alarm_en,
    input  logic              pio_req,
    input  logic [ACC_W-1:0]  acc_val,
    input  logic              acc_stb,
    input  logic [TEMP_W-1:0] temp_val,
    input  logic              temp_stb,
    input  logic [1:0]        clr_flags,
    output logic [7:0]        rf_addr,
    input  logic [7:0]        rf_rdata,
    output logic              pio_n,
    output logic [1:0]        alarm_flags,
    output logic [1:0]        window_out
);

    lim_set_t    lim;
    chan_state_t st_acc;
    chan_state_t st_tmp;

    wta_limit_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .rf_addr  (rf_addr),
        .rf_rdata (rf_rdata),
        .lim      (lim)
    );

    wta_win_chan #(.VAL_W(ACC_W), .CW(ACC_CMP_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .en     (alarm_en),
        .value  (acc_val),
        .stb    (acc_stb),
        .clr    (clr_flags[CH_ACC]),
        .lim_up (lim.acc_up),
        .lim_dn (lim.acc_dn),
        .st     (st_acc)
    );

    wta_win_chan #(.VAL_W(TEMP_W), .CW(TMP_CMP_W)) u_tmp (
        .clk    (clk),
        .rst    (rst),
        .en     (alarm_en),
        .value  (temp_val),
        .stb    (temp_stb),
        .clr    (clr_flags[CH_TMP]),
        .lim_up (lim.tmp_up),
        .lim_dn (lim.tmp_dn),
        .st     (st_tmp)
    );

    assign alarm_flags = {st_tmp.sticky, st_acc.sticky};
    assign window_out  = {st_tmp.outside, st_acc.outside};

    wta_pio_drive u_pio (
        .clk       (clk),
        .rst       (rst),
        .en        (alarm_en),
        .req       (pio_req),
        .any_alarm (|alarm_flags),
        .pio_n     (pio_n)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (pio_n && alarm_flags == 2'b00 && window_out == 2'b00)); // R1

endmodule

// File: tb/thr_alarm_tb.sv
module thr_alarm_tb;

    localparam int ACC_W  = 16;
    localparam int TEMP_W = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              alarm_en;
    logic              pio_req;
    logic [ACC_W-1:0]  acc_val;
    logic              acc_stb;
    logic [TEMP_W-1:0] temp_val;
    logic              temp_stb;
    logic [1:0]        clr_flags;
    logic [7:0]        rf_addr;
    logic [7:0]        rf_rdata;
    logic              pio_n;
    logic [1:0]        alarm_flags;
    logic [1:0]        window_out;

    logic [7:0] mem [6];

    always #5 clk = ~clk;

    thr_alarm #(.ACC_W(ACC_W), .TEMP_W(TEMP_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .alarm_en    (alarm_en),
        .pio_req     (pio_req),
        .acc_val     (acc_val),
        .acc_stb     (acc_stb),
        .temp_val    (temp_val),
        .temp_stb    (temp_stb),
        .clr_flags   (clr_flags),
        .rf_addr     (rf_addr),
        .rf_rdata    (rf_rdata),
        .pio_n       (pio_n),
        .alarm_flags (alarm_flags),
        .window_out  (window_out)
    );

    // Limit RAM, combinational read
    always_comb begin
        if (rf_addr >= 8'h80 && rf_addr <= 8'h85) begin
            rf_rdata = mem[int'(rf_addr) - 128];
        end else begin
            rf_rdata = 8'h00;
        end
    end

    // Reference model
    bit   [1:0] m_out;
    bit   [1:0] m_st;
    bit         m_pio;
    bit   [1:0] o_now;
    bit   [1:0] s_now;
    bit   [1:0] n_out;
    bit   [1:0] n_st;
    integer     a_v;
    integer     a_up;
    integer     a_dn;
    integer     t_v;
    integer     t_up;
    integer     t_dn;
    bit         started = 1'b0;

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            m_out = 2'b00;
            m_st  = 2'b00;
            m_pio = 1'b1;
        end else begin
            a_v  = int'($signed(acc_val));
            a_up = int'($signed({mem[0], mem[1]}));
            a_dn = int'($signed({mem[2], mem[3]}));
            t_v  = int'($signed(temp_val[TEMP_W-1 -: 8]));
            t_up = int'($signed(mem[4]));
            t_dn = int'($signed(mem[5]));
            o_now[0] = (a_v > a_up) || (a_v < a_dn);
            o_now[1] = (t_v > t_up) || (t_v < t_dn);
            s_now    = {temp_stb, acc_stb};
            m_pio    = alarm_en ? (m_st == 2'b00) : !pio_req;
            if (!alarm_en) begin
                m_out = 2'b00;
                m_st  = 2'b00;
            end else begin
                for (int c = 0; c < 2; c++) begin
                    n_out[c] = s_now[c] ? o_now[c] : m_out[c];
                    n_st[c]  = (s_now[c] && o_now[c]) ||
                               (m_st[c] && !(clr_flags[c] && !n_out[c]));
                end
                m_out = n_out;
                m_st  = n_st;
            end
        end
    end

    // Comparison on every falling edge
    int    nvec = 0;
    int    nfail = 0;
    string phase = "R1";
    bit    finished = 1'b0;

    always @(negedge clk) begin
        if (started && !finished) begin
            nvec++;
            if (pio_n !== m_pio || alarm_flags !== m_st || window_out !== m_out) begin
                nfail++;
                $display("FAIL %s t=%0t pio_n/flags/window actual=%b/%b/%b expected=%b/%b/%b",
                         phase, $time, pio_n, alarm_flags, window_out, m_pio, m_st, m_out);
            end
            if (!rst) begin
                nvec++;
                if (rf_addr < 8'h80 || rf_addr > 8'h85) begin
                    nfail++;
                    $display("FAIL R2 rf_addr actual=%h expected=80..85", rf_addr);
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic set_limits(int aup, int adn, int tup, int tdn);
        mem[0] = aup[15:8]; mem[1] = aup[7:0];
        mem[2] = adn[15:8]; mem[3] = adn[7:0];
        mem[4] = tup[7:0];  mem[5] = tdn[7:0];
        tick(8);
    endtask

    task automatic acc_sample(int v, bit [1:0] clr = 2'b00);
        acc_val   = ACC_W'(v);
        acc_stb   = 1'b1;
        clr_flags = clr;
        tick();
        acc_stb   = 1'b0;
        clr_flags = 2'b00;
        tick(2);
    endtask

    task automatic tmp_sample(int v, int frac, bit [1:0] clr = 2'b00);
        temp_val  = {v[7:0], frac[1:0]};
        temp_stb  = 1'b1;
        clr_flags = clr;
        tick();
        temp_stb  = 1'b0;
        clr_flags = 2'b00;
        tick(2);
    endtask

    task automatic clear(bit [1:0] m);
        clr_flags = m;
        tick();
        clr_flags = 2'b00;
        tick(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; alarm_en = 1'b0; pio_req = 1'b0;
        acc_val = '0; acc_stb = 1'b0; temp_val = '0; temp_stb = 1'b0;
        clr_flags = 2'b00;
        mem[0] = 8'h03; mem[1] = 8'hE8;   // acc upper 1000
        mem[2] = 8'hFE; mem[3] = 8'h0C;   // acc lower -500
        mem[4] = 8'd40; mem[5] = 8'hF6;   // temp 40 / -10
        tick(4);
        rst = 1'b0;
        phase = "R2";
        tick(8);

        // R8: pin follows request, strobes ignored while disabled
        phase = "R8";
        pio_req = 1'b1; tick(2);
        pio_req = 1'b0; tick(2);
        acc_sample(5000);
        tmp_sample(100, 0);
        pio_req = 1'b1; tick(1);

        // R3: accumulator window edges
        alarm_en = 1'b1;
        phase = "R3";
        acc_sample(1000);
        acc_sample(-500);
        acc_sample(1001);
        phase = "R7";
        pio_req = 1'b0; tick(2);
        pio_req = 1'b1; tick(2);
        // R6: clear ignored while outside
        phase = "R6";
        clear(2'b01);
        phase = "R5";
        acc_val = 16'd0; tick(3);
        acc_sample(0);
        phase = "R6";
        clear(2'b01);
        phase = "R3";
        acc_sample(-501);
        acc_sample(200, 2'b01);

        // R4: temperature window edges, fractional bits ignored
        phase = "R4";
        tmp_sample(40, 3);
        tmp_sample(41, 0);
        tmp_sample(-10, 2, 2'b10);
        tmp_sample(-11, 0);
        tmp_sample(0, 1);
        clear(2'b10);

        // R9: excursion and clear in the same cycle
        phase = "R9";
        acc_sample(30000, 2'b01);
        tmp_sample(-128, 0, 2'b10);
        acc_sample(10);
        tmp_sample(5, 0);
        clear(2'b11);

        // R8: disabling clears live flags
        phase = "R8";
        acc_sample(2000);
        alarm_en = 1'b0; pio_req = 1'b0;
        tick(3);
        alarm_en = 1'b1;
        tick(2);

        // R2: reload limits and retest, high and low bytes distinct
        phase = "R2";
        set_limits(16'h1234, 16'hF00F, 8'h05, 8'hFB);
        acc_sample(16'h1234);
        acc_sample(16'h1235);
        acc_sample(-4082, 2'b01);
        acc_sample(-4081, 2'b01);
        tmp_sample(6, 0);
        tmp_sample(-5, 0, 2'b10);
        tmp_sample(-6, 0);
        tick(4);

        finish_run();
    end

endmodule